// File: doc/BRIEF.md
# Three-Wire Display Command Receiver

This block takes framed serial commands from a host controller and turns them into the stored state of a multiplexed display: one segment word per grid (three grids) and one brightness word. A frame opens when the select line rises, carries its bits on rising edges of a shift clock, and is committed when the select line falls. The command number travels in the last three bits of the frame, after the payload.

The three host lines are oversampled in the block's own clock domain: each passes through a synchronizer, and edges are found by comparing each line with its previous sample. A full-width shift register keeps the most recent bits. A bit counter, cleared when a frame opens, records how many bits arrived. When the frame closes, a decoder reads the mode from the three newest bits. It writes the payload only when the bit count matches the frame length for that mode. Segment frames can write all three grid words at once or write one grid word.

Top module: `vfd_cmd_rx`

## Requirements
- R1: After reset, the three segment words and the brightness word all read zero.
- R2: A 59-bit frame with mode 0 writes the same 56-bit payload to all three segment words and leaves the brightness word unchanged. The first payload bit shifted in lands in bit 0 of the word, and the last payload bit lands in bit 55.
- R3: The mode value is M0 + 2*M1 + 4*M2, and M0 is the first of the three trailing bits. A 59-bit frame with mode 1, 2 or 3 writes only segment word 1, 2 or 3. The other two segment words and the brightness word keep their values.
- R4: A 13-bit frame with mode 4 loads the 10-bit brightness word, with the first payload bit as its most significant bit. The segment words do not change.
- R5: Modes 5, 6 and 7 change no output word.
- R6: A frame is discarded when its bit count differs from the length its mode needs: 59 bits for modes 0 to 3, 13 bits for mode 4. A discarded frame changes no output word.
- R7: Output words change only after a falling edge of the select line. Shift-clock edges and data changes while the select line is low are ignored: they neither shift nor count, and they do not disturb the frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_i | input | 1 | Frame select from the host; high while a frame is open |
| sclk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| sdin_i | input | 1 | Serial data, positive logic |
| seg_g1_o | output | 56 | Segment word for grid 1 |
| seg_g2_o | output | 56 | Segment word for grid 2 |
| seg_g3_o | output | 56 | Segment word for grid 3 |
| dim_o | output | 10 | Brightness word |

## Verification
The bench builds the block with its default widths: 56 segment bits, 10 brightness bits and two synchronizer stages. With these widths the two real frame lengths, 59 and 13, can be reached directly, along with the off-by-one lengths that are one bit short or that belong to the other mode. The patterns have distinct bits at the two ends of the payload, so a reversed bit order or a swapped mode-bit order shows up in the results. Clock activity while the select line is low is also driven ahead of a valid frame, to check that it leaves no trace.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;

  localparam int MODE_W = 3;
  localparam int GRIDS  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_ALL  = 3'd0,
    MODE_G1   = 3'd1,
    MODE_G2   = 3'd2,
    MODE_G3   = 3'd3,
    MODE_DIM  = 3'd4,
    MODE_RSV5 = 3'd5,
    MODE_RSV6 = 3'd6,
    MODE_RSV7 = 3'd7
  } cmd_mode_e;

  // The three newest bits: tail[2] came first (M0), tail[0] came last (M2).
  function automatic cmd_mode_e tail_to_mode(input logic [MODE_W-1:0] tail);
    return cmd_mode_e'({tail[0], tail[1], tail[2]});
  endfunction

endpackage

// File: rtl/vfd_cmd_sync.sv
module vfd_cmd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[b] <= '0;
        else        chain_q[b] <= async_i[b];
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[b] <= '0;
        else        chain_q[b] <= {chain_q[b][STAGES-2:0], async_i[b]};
      end
    end
    assign sync_o[b] = chain_q[b][STAGES-1];
  end

endmodule

// File: rtl/vfd_cmd_shifter.sv
module vfd_cmd_shifter #(
  parameter int FRAME_W = 59,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_s,
  input  logic               sclk_s,
  input  logic               sdin_s,
  output logic [FRAME_W-1:0] shreg_o,
  output logic [CNT_W-1:0]   nbits_o,
  output logic               load_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  logic               cs_q, sclk_q;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               cs_rise, cs_fall, shift_en;

  always_comb begin
    cs_rise  = cs_s & ~cs_q;
    cs_fall  = ~cs_s & cs_q;
    shift_en = cs_s & sclk_s & ~sclk_q;

    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[FRAME_W-2:0], sdin_s};

    cnt_d = cnt_q;
    if (cs_rise)                              cnt_d = shift_en ? CNT_W'(1) : '0;
    else if (shift_en && (cnt_q != CNT_MAX))  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      cs_q   <= cs_s;
      sclk_q <= sclk_s;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign shreg_o = sr_q;
  assign nbits_o = cnt_q;
  assign load_o  = cs_fall;

endmodule

// File: rtl/vfd_cmd_decoder.sv
module vfd_cmd_decoder
  import vfd_cmd_pkg::*;
#(
  parameter int SEG_W = 56,
  parameter int DIM_W = 10,
  parameter int CNT_W = 6
) (
  input  logic [SEG_W+MODE_W-1:0] shreg_i,
  input  logic [CNT_W-1:0]        nbits_i,
  input  logic                    load_i,
  output logic [MODE_W-1:0]       mode_o,
  output logic [GRIDS-1:0]        seg_we_o,
  output logic                    dim_we_o,
  output logic [SEG_W-1:0]        seg_data_o,
  output logic [DIM_W-1:0]        dim_data_o
);

  localparam int FRAME_W = SEG_W + MODE_W;
  localparam logic [CNT_W-1:0] SEG_LEN = CNT_W'(SEG_W + MODE_W);
  localparam logic [CNT_W-1:0] DIM_LEN = CNT_W'(DIM_W + MODE_W);

  cmd_mode_e mode;
  logic      seg_len_ok, dim_len_ok;

  for (genvar k = 0; k < SEG_W; k++) begin : g_seg_map
    assign seg_data_o[k] = shreg_i[FRAME_W-1-k];
  end

  assign dim_data_o = shreg_i[DIM_W+MODE_W-1:MODE_W];

  always_comb begin
    mode       = tail_to_mode(shreg_i[MODE_W-1:0]);
    seg_len_ok = (nbits_i == SEG_LEN);
    dim_len_ok = (nbits_i == DIM_LEN);
    seg_we_o   = '0;
    dim_we_o   = 1'b0;
    if (load_i) begin
      unique case (mode)
        MODE_ALL: if (seg_len_ok) seg_we_o = '1;
        MODE_G1:  if (seg_len_ok) seg_we_o = 3'b001;
        MODE_G2:  if (seg_len_ok) seg_we_o = 3'b010;
        MODE_G3:  if (seg_len_ok) seg_we_o = 3'b100;
        MODE_DIM: if (dim_len_ok) dim_we_o = 1'b1;
        default:  ;
      endcase
    end
  end

  assign mode_o = mode;

endmodule

// File: rtl/vfd_cmd_latches.sv
module vfd_cmd_latches
  import vfd_cmd_pkg::*;
#(
  parameter int SEG_W = 56,
  parameter int DIM_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [GRIDS-1:0]             seg_we_i,
  input  logic                         dim_we_i,
  input  logic [SEG_W-1:0]             seg_data_i,
  input  logic [DIM_W-1:0]             dim_data_i,
  output logic [GRIDS-1:0][SEG_W-1:0]  seg_o,
  output logic [DIM_W-1:0]             dim_o
);

  logic [DIM_W-1:0] dim_q, dim_d;

  for (genvar g = 0; g < GRIDS; g++) begin : g_grid
    logic [SEG_W-1:0] word_q, word_d;

    always_comb begin
      word_d = word_q;
      if (seg_we_i[g]) word_d = seg_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign seg_o[g] = word_q;
  end

  always_comb begin
    dim_d = dim_q;
    if (dim_we_i) dim_d = dim_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dim_q <= '0;
    else        dim_q <= dim_d;
  end

  assign dim_o = dim_q;

endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx
  import vfd_cmd_pkg::*;
#(
  parameter int SEG_W       = 56,
  parameter int DIM_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_i,
  input  logic             sclk_i,
  input  logic             sdin_i,
  output logic [SEG_W-1:0] seg_g1_o,
  output logic [SEG_W-1:0] seg_g2_o,
  output logic [SEG_W-1:0] seg_g3_o,
  output logic [DIM_W-1:0] dim_o
);

  localparam int FRAME_W = SEG_W + MODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  logic [2:0]                  line_s;
  logic [FRAME_W-1:0]          shreg;
  logic [CNT_W-1:0]            bit_cnt;
  logic                        load_pulse;
  logic [MODE_W-1:0]           frame_mode;
  logic [GRIDS-1:0]            seg_we;
  logic                        dim_we;
  logic [SEG_W-1:0]            seg_data;
  logic [DIM_W-1:0]            dim_data;
  logic [GRIDS-1:0][SEG_W-1:0] seg_words;

  vfd_cmd_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({cs_i, sclk_i, sdin_i}),
    .sync_o  (line_s)
  );

  vfd_cmd_shifter #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_s    (line_s[2]),
    .sclk_s  (line_s[1]),
    .sdin_s  (line_s[0]),
    .shreg_o (shreg),
    .nbits_o (bit_cnt),
    .load_o  (load_pulse)
  );

  vfd_cmd_decoder #(
    .SEG_W (SEG_W),
    .DIM_W (DIM_W),
    .CNT_W (CNT_W)
  ) u_dec (
    .shreg_i    (shreg),
    .nbits_i    (bit_cnt),
    .load_i     (load_pulse),
    .mode_o     (frame_mode),
    .seg_we_o   (seg_we),
    .dim_we_o   (dim_we),
    .seg_data_o (seg_data),
    .dim_data_o (dim_data)
  );

  vfd_cmd_latches #(
    .SEG_W (SEG_W),
    .DIM_W (DIM_W)
  ) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_we_i   (seg_we),
    .dim_we_i   (dim_we),
    .seg_data_i (seg_data),
    .dim_data_i (dim_data),
    .seg_o      (seg_words),
    .dim_o      (dim_o)
  );

  assign seg_g1_o = seg_words[0];
  assign seg_g2_o = seg_words[1];
  assign seg_g3_o = seg_words[2];

endmodule

// File: rtl/vfd_cmd_rx_chk.sv
module vfd_cmd_rx_chk #(
  parameter int SEG_W = 56,
  parameter int DIM_W = 10,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] nbits_i,
  input logic [SEG_W-1:0] g1,
  input logic [SEG_W-1:0] g2,
  input logic [SEG_W-1:0] g3,
  input logic [DIM_W-1:0] dim
);

  localparam logic [CNT_W-1:0] SEG_LEN = CNT_W'(SEG_W + 3);
  localparam logic [CNT_W-1:0] DIM_LEN = CNT_W'(DIM_W + 3);

  // R7: without a load, no word moves
  a_r7_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(g1) && $stable(g2) && $stable(g3) && $stable(dim)));

  // R2: broadcast leaves the three grid words equal and brightness untouched
  a_r2_broadcast_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == 3'd0 && nbits_i == SEG_LEN) |=>
      (g1 == g2 && g2 == g3 && $stable(dim)));

  // R3: a grid-1 frame leaves the other words alone
  a_r3_grid1_only: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == 3'd1) |=> ($stable(g2) && $stable(g3) && $stable(dim)));

  // R3: a grid-3 frame leaves the other words alone
  a_r3_grid3_only: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == 3'd3) |=> ($stable(g1) && $stable(g2) && $stable(dim)));

  // R4: a brightness frame leaves the segment words alone
  a_r4_dim_keeps_segments: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == 3'd4) |=> ($stable(g1) && $stable(g2) && $stable(g3)));

  // R5: reserved modes are inert
  a_r5_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i >= 3'd5) |=>
      ($stable(g1) && $stable(g2) && $stable(g3) && $stable(dim)));

  // R6: a segment mode with the wrong length is dropped
  a_r6_seg_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i <= 3'd3 && nbits_i != SEG_LEN) |=>
      ($stable(g1) && $stable(g2) && $stable(g3) && $stable(dim)));

  // R6: a brightness mode with the wrong length is dropped
  a_r6_dim_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == 3'd4 && nbits_i != DIM_LEN) |=> $stable(dim));

endmodule

bind vfd_cmd_rx vfd_cmd_rx_chk #(
  .SEG_W (SEG_W),
  .DIM_W (DIM_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_i  (load_pulse),
  .mode_i  (frame_mode),
  .nbits_i (bit_cnt),
  .g1      (seg_g1_o),
  .g2      (seg_g2_o),
  .g3      (seg_g3_o),
  .dim     (dim_o)
);

// File: tb/vfd_cmd_rx_tb_top.sv
module vfd_cmd_rx_tb_top;

  localparam int SEG_W = 56;
  localparam int DIM_W = 10;
  localparam int FW    = SEG_W + 3;

  logic clk = 1'b0;
  logic rst_n, cs, sclk, sdin;
  logic [SEG_W-1:0] g1, g2, g3;
  logic [DIM_W-1:0] dim;

  logic [SEG_W-1:0] e1, e2, e3;
  logic [DIM_W-1:0] edim;
  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  vfd_cmd_rx #(.SEG_W(SEG_W), .DIM_W(DIM_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdin_i(sdin),
    .seg_g1_o(g1), .seg_g2_o(g2), .seg_g3_o(g3), .dim_o(dim)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [FW-1:0] mk_seg(input logic [SEG_W-1:0] d, input logic [2:0] m);
    logic [FW-1:0] f;
    f = '0;
    for (int k = 0; k < SEG_W; k++) f[FW-1-k] = d[k];
    f[2] = m[0]; f[1] = m[1]; f[0] = m[2];
    return f;
  endfunction

  function automatic logic [FW-1:0] mk_dim(input logic [DIM_W-1:0] v, input logic [2:0] m);
    logic [FW-1:0] f;
    f = '0;
    f[DIM_W+2:3] = v;
    f[2] = m[0]; f[1] = m[1]; f[0] = m[2];
    return f;
  endfunction

  // sends f[n-1] first, down to f[0]
  task automatic send(input logic [FW-1:0] f, input int n);
    cs = 1'b1; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = f[i]; sclk = 1'b0; tick(4);
      sclk = 1'b1; tick(4);
    end
    sclk = 1'b0; tick(4);
    cs = 1'b0; tick(12);
  endtask

  task automatic check_all(input string req);
    n_checks++;
    if (g1 !== e1 || g2 !== e2 || g3 !== e3 || dim !== edim) begin
      n_fail++;
      $display("FAIL %s: actual g1=%h g2=%h g3=%h dim=%h expected g1=%h g2=%h g3=%h dim=%h",
               req, g1, g2, g3, dim, e1, e2, e3, edim);
    end
  endtask

  task automatic t_reset;
    e1 = '0; e2 = '0; e3 = '0; edim = '0;
    check_all("R1 reset state");
  endtask

  task automatic t_broadcast;
    logic [SEG_W-1:0] d;
    d = 56'h00_0000_0000_0001;          // only the first payload bit set
    send(mk_seg(d, 3'd0), FW);
    e1 = d; e2 = d; e3 = d;
    check_all("R2 broadcast first bit to bit0");
    d = 56'h80_F0A5_5A0F_3C01;
    send(mk_seg(d, 3'd0), FW);
    e1 = d; e2 = d; e3 = d;
    check_all("R2 broadcast pattern");
  endtask

  task automatic t_single;
    logic [SEG_W-1:0] d;
    d = 56'h12_3456_789A_BCDE;
    send(mk_seg(d, 3'd1), FW); e1 = d;
    check_all("R3 grid1 only");
    d = 56'hFE_DCBA_9876_5432;
    send(mk_seg(d, 3'd2), FW); e2 = d;
    check_all("R3 grid2 only");
    d = 56'h80_0000_0000_0000;          // only the last payload bit set
    send(mk_seg(d, 3'd3), FW); e3 = d;
    check_all("R3 grid3 only last bit");
  endtask

  task automatic t_dim;
    send(mk_dim(10'h3F8, 3'd4), DIM_W + 3); edim = 10'h3F8;
    check_all("R4 dim 0x3F8");
    send(mk_dim(10'h201, 3'd4), DIM_W + 3); edim = 10'h201;
    check_all("R4 dim msb first");
  endtask

  task automatic t_noop;
    for (int m = 5; m < 8; m++) begin
      send(mk_seg(56'hFF_FFFF_FFFF_FFFF, 3'(m)), FW);
      check_all("R5 reserved seg-length frame");
      send(mk_dim(10'h155, 3'(m)), DIM_W + 3);
      check_all("R5 reserved dim-length frame");
    end
  endtask

  task automatic t_length;
    logic [FW-1:0] f;
    f = mk_seg(56'hAA_AAAA_AAAA_AAAA, 3'd1);
    send(f, FW - 1);
    check_all("R6 58-bit grid1 frame dropped");
    send(mk_seg(56'h55_5555_5555_5555, 3'd0), FW + 1);
    check_all("R6 60-bit broadcast dropped");
    send(mk_seg(56'h0F_0F0F_0F0F_0F0F, 3'd4), FW);
    check_all("R6 59-bit dim frame dropped");
    send(mk_dim(10'h0AA, 3'd0), DIM_W + 3);
    check_all("R6 13-bit broadcast dropped");
    send(mk_dim(10'h0AA, 3'd4), DIM_W + 2);
    check_all("R6 12-bit dim frame dropped");
    send('0, 0);
    check_all("R6 empty frame dropped");
  endtask

  task automatic t_cs_low;
    logic [SEG_W-1:0] d;
    // clock activity with select low
    for (int i = 0; i < 20; i++) begin
      sdin = i[0]; sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    tick(8);
    check_all("R7 clocks with select low ignored");
    // partial frame: outputs stay put while open
    d = 56'h3C_3C3C_3C3C_3C3C;
    cs = 1'b1; tick(4);
    for (int i = FW - 1; i >= 20; i--) begin
      sdin = mk_seg(d, 3'd2)[i]; sclk = 1'b0; tick(4); sclk = 1'b1; tick(4);
    end
    check_all("R7 no change while frame open");
    sclk = 1'b0; tick(4); cs = 1'b0; tick(12);
    check_all("R7 short frame after close dropped");
    // stray clocks then a full frame must land exactly
    for (int i = 0; i < 7; i++) begin
      sdin = 1'b1; sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    send(mk_seg(d, 3'd2), FW); e2 = d;
    check_all("R7 frame after stray clocks intact");
  endtask

  initial begin
    rst_n = 1'b0; cs = 1'b0; sclk = 1'b0; sdin = 1'b0;
    tick(5);
    t_reset;
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_broadcast;
    t_single;
    t_dim;
    t_noop;
    t_length;
    t_cs_low;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule